// File: doc/BRIEF.md
# Hypercube Node Message Router

This block is the switch that sits at one vertex of a binary hypercube of processors. A network of dimension `DIM` holds 2^DIM nodes, and each node carries a `DIM`-bit tag that is unique in the network. Neighbour channel `k` of a node links it to the node whose tag differs from its own only in bit `k`. The router has `DIM` neighbour ports and one local port, and each port is a bidirectional pair. Index `DIM` of every port vector is the local port: it takes injections from the processor on the input side and makes deliveries to the processor on the output side.

A message is made of flits. It opens with a header flit and continues with a fixed number of payload flits. For every header that arrives, the router XORs the header's destination tag with its own tag. A zero result sends the message to the local delivery port. Any other result sends it out on the neighbour channel of the lowest set bit. Because of this rule, the differing bits are always resolved in ascending order. Messages that only pass through the node never reach the processor. When several inputs contend for one output, a round-robin arbiter picks the winner. The output then stays locked to that input until the message's last flit has gone.

Each output has a single register stage. A flit therefore crosses one router per clock, and an output takes a new flit only after its register has been emptied.

Top module: `hcr_router`

## Requirements
- R1: After reset, every output valid is low. No output valid rises until a flit has been accepted.
- R2: A header whose destination field equals `node_id` leaves on the local port (index `DIM`). A message is delivered locally only at the node whose tag equals its destination, and transit traffic never appears on a local port.
- R3: A header whose destination differs from `node_id` leaves on neighbour output `k`, where `k` is the lowest bit position in which the two tags differ. Neighbour output `k` of node `n` connects to input `k` of node `n ^ (1<<k)`.
- R4: Across a network of these routers, every message reaches its destination after exactly popcount(src ^ dest) neighbour hops.
- R5: Header flit layout: bits `[DIM-1:0]` hold the destination tag and bits `[DIM+LW-1:DIM]` hold N, the payload flit count. Exactly N payload flits follow, and N may be 0. All flit bits are carried through unchanged, and payload flits keep their order.
- R6: Once a header wins an output, that output carries flits only from the same input until the message's last flit has passed. Flits from two messages never interleave on one output.
- R7: Each output arbitrates in round-robin order. After reset the pointer is 0. The arbiter scans input indices upward from the pointer and wraps around. When the winner's last flit passes, the pointer moves to the winner's index + 1.
- R8: A flit moves only in a cycle where both valid and ready are high. A stalled output holds its valid and data stable, and that stall withholds ready from the granted input.
- R9: A header accepted on an input at clock edge c appears as a valid flit on its output right after edge c, provided that output was free. This makes one cycle per hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | DIM | This node's tag |
| in_valid | input | DIM+1 | Input flit valid, one bit per port (index DIM = local injection) |
| in_data | input | (DIM+1)*FW | Input flits, port p at bits [p*FW +: FW] |
| in_ready | output | DIM+1 | Input accept, one bit per port |
| out_valid | output | DIM+1 | Output flit valid (index DIM = local delivery) |
| out_data | output | (DIM+1)*FW | Output flits, port p at bits [p*FW +: FW] |
| out_ready | input | DIM+1 | Downstream accept, one bit per port |

## Verification
A flit accepted at an input appears on its output one edge later. A message injected at the source node's local port is therefore offered at the destination's local delivery port hops+1 edges after injection, unless it was stalled along the way. The bench builds the whole 2^DIM network around the router. It samples every link and port handshake at the falling edge, where the values reflect the coming transfer, and changes stimulus just after the rising edge. A behavioural scoreboard is then updated for each transfer in the clock where it happens. Two directed rounds of simultaneous one-hop messages into node 0 pin down the exact delivery cycle and the round-robin order.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // Index of the lowest set bit among the first `dims` bits; `dims` when none is set.
  function automatic int unsigned first_diff_dim(input logic [31:0] diff, input int unsigned dims);
    int unsigned r;
    r = dims;
    for (int b = 31; b >= 0; b--) begin
      if (b < int'(dims) && diff[b]) r = int'(b);
    end
    return r;
  endfunction
endpackage

// File: rtl/hcr_in_track.sv
module hcr_in_track #(
  parameter int DIM = 3,
  parameter int LW  = 4,
  parameter int PW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DIM-1:0] node_id,
  input  logic [DIM-1:0] hdr_dst,
  input  logic [LW-1:0]  hdr_len,
  input  logic          fire,
  output logic          hdr,
  output logic [PW-1:0] want,
  output logic          last
);
  logic          busy;
  logic [PW-1:0] port_q;
  logic [LW-1:0] cnt_q;
  logic [PW-1:0] route;

  always_comb route = PW'(hcr_pkg::first_diff_dim(32'(node_id ^ hdr_dst), DIM));

  assign hdr  = !busy;
  assign want = busy ? port_q : route;
  assign last = busy ? (cnt_q == LW'(1)) : (hdr_len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      port_q <= '0;
      cnt_q  <= '0;
    end else if (fire) begin
      if (!busy) begin
        if (hdr_len != '0) begin
          busy   <= 1'b1;
          port_q <= route;
          cnt_q  <= hdr_len;
        end
      end else begin
        cnt_q <= cnt_q - LW'(1);
        if (cnt_q == LW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hcr_rr_arb.sv
module hcr_rr_arb #(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          move,
  input  logic          move_last,
  output logic [NP-1:0] gnt,
  output logic          locked
);
  logic [PW-1:0] owner, ptr, pick, cur;
  logic          found;

  always_comb begin
    pick  = ptr;
    found = 1'b0;
    for (int j = 0; j < NP; j++) begin
      int idx;
      idx = int'(ptr) + j;
      if (idx >= NP) idx = idx - NP;
      if (!found && req[idx]) begin
        pick  = PW'(idx);
        found = 1'b1;
      end
    end
    cur = locked ? owner : pick;
    gnt = '0;
    if (locked) gnt[owner] = req[owner];
    else if (found) gnt[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (move) begin
      if (move_last) begin
        locked <= 1'b0;
        ptr    <= (cur == PW'(NP - 1)) ? '0 : cur + PW'(1);
      end else begin
        locked <= 1'b1;
        owner  <= cur;
      end
    end
  end
endmodule

// File: rtl/hcr_out_stage.sv
module hcr_out_stage #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] din,
  input  logic          rdy,
  output logic          valid,
  output logic [FW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (rdy) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hcr_router.sv
module hcr_router #(
  parameter int DIM = 3,
  parameter int FW  = 16,
  parameter int LW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIM-1:0]        node_id,
  input  logic [DIM:0]          in_valid,
  input  logic [(DIM+1)*FW-1:0] in_data,
  output logic [DIM:0]          in_ready,
  output logic [DIM:0]          out_valid,
  output logic [(DIM+1)*FW-1:0] out_data,
  input  logic [DIM:0]          out_ready
);
  localparam int NP = DIM + 1;
  localparam int PW = $clog2(NP);

  logic [NP-1:0]     hdr_v, last_v, fire, empty, load, mlast, locked;
  logic [PW-1:0]     want [NP];
  logic [NP-1:0]     req  [NP];
  logic [NP-1:0]     gnt  [NP];
  logic [FW-1:0]     mux_d [NP];
  logic [NP*NP-1:0]  gnt_flat;
  logic [NP*DIM-1:0] dst_flat;

  assign fire = in_valid & in_ready;

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign dst_flat[i*DIM +: DIM] = in_data[i*FW +: DIM];
    hcr_in_track #(.DIM(DIM), .LW(LW), .PW(PW)) u_trk (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .hdr_dst(in_data[i*FW +: DIM]), .hdr_len(in_data[i*FW+DIM +: LW]),
      .fire(fire[i]), .hdr(hdr_v[i]), .want(want[i]), .last(last_v[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < NP; i++) req[o][i] = in_valid[i] && (want[i] == PW'(o));
    end
    always_comb begin
      mux_d[o] = '0;
      mlast[o] = 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (gnt[o][i]) begin
          mux_d[o] = mux_d[o] | in_data[i*FW +: FW];
          mlast[o] = mlast[o] | last_v[i];
        end
      end
    end
    assign load[o] = (|gnt[o]) && empty[o];
    assign empty[o] = !out_valid[o];
    assign gnt_flat[o*NP +: NP] = gnt[o];

    hcr_rr_arb #(.NP(NP), .PW(PW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req[o]), .move(load[o]), .move_last(mlast[o]),
      .gnt(gnt[o]), .locked(locked[o]));

    hcr_out_stage #(.FW(FW)) u_stg (
      .clk(clk), .rst_n(rst_n), .load(load[o]), .din(mux_d[o]), .rdy(out_ready[o]),
      .valid(out_valid[o]), .data(out_data[o*FW +: FW]));
  end

  always_comb begin
    in_ready = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        in_ready[i] = in_ready[i] | (gnt[o][i] & empty[o]);
  end
endmodule

// File: rtl/hcr_router_chk.sv
module hcr_router_chk #(
  parameter int DIM = 3,
  parameter int FW  = 16,
  parameter int NP  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIM-1:0]    node_id,
  input logic [NP-1:0]     in_valid,
  input logic [NP-1:0]     in_ready,
  input logic [NP-1:0]     in_hdr,
  input logic [NP*DIM-1:0] dst_flat,
  input logic [NP*NP-1:0]  gnt_flat,
  input logic [NP-1:0]     out_valid,
  input logic [NP-1:0]     out_ready,
  input logic [NP*FW-1:0]  out_data
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (out_valid == '0));

  for (genvar o = 0; o < NP; o++) begin : g_o
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*FW +: FW])));
    a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_flat[o*NP +: NP]));
  end

  for (genvar i = 0; i < NP; i++) begin : g_i
    a_r2_local_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_ready[i] && in_hdr[i] && dst_flat[i*DIM +: DIM] == node_id)
      |-> gnt_flat[DIM*NP + i]);
    for (genvar k = 0; k < DIM; k++) begin : g_k
      a_r3_dim_differs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[i] && in_ready[i] && in_hdr[i] && gnt_flat[k*NP + i])
        |-> (dst_flat[i*DIM + k] != node_id[k]));
    end
  end
endmodule

bind hcr_router hcr_router_chk #(.DIM(DIM), .FW(FW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .in_valid(in_valid), .in_ready(in_ready),
  .in_hdr(hdr_v), .dst_flat(dst_flat), .gnt_flat(gnt_flat), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data));

// File: tb/tb_hcr_router.sv
`timescale 1ns/100ps
module tb_hcr_router;
  parameter int DIM = 3;
  localparam int FW = 16, LW = 4, NP = DIM + 1, N = 1 << DIM;
  localparam int MAXF = 64, MAXM = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  wire [NP-1:0]    iv [N], ir [N], ov [N], orr [N];
  wire [NP*FW-1:0] idt [N], odt [N];
  logic            inj_v [N], dly_r [N];
  logic [FW-1:0]   inj_d [N];

  for (genvar n = 0; n < N; n++) begin : g_net
    assign iv[n][DIM]             = inj_v[n];
    assign idt[n][DIM*FW +: FW]   = inj_d[n];
    assign orr[n][DIM]            = dly_r[n];
    for (genvar k = 0; k < DIM; k++) begin : g_lnk
      assign iv[n][k]           = ov[n ^ (1 << k)][k];
      assign idt[n][k*FW +: FW] = odt[n ^ (1 << k)][k*FW +: FW];
      assign orr[n][k]          = ir[n ^ (1 << k)][k];
    end
    if (n != 0) begin : g_peer
      hcr_router #(.DIM(DIM), .FW(FW), .LW(LW)) u_rtr (
        .clk(clk), .rst_n(rst_n), .node_id(DIM'(n)), .in_valid(iv[n]), .in_data(idt[n]),
        .in_ready(ir[n]), .out_valid(ov[n]), .out_data(odt[n]), .out_ready(orr[n]));
    end
  end

  hcr_router #(.DIM(DIM), .FW(FW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .node_id('0), .in_valid(iv[0]), .in_data(idt[0]),
    .in_ready(ir[0]), .out_valid(ov[0]), .out_data(odt[0]), .out_ready(orr[0]));

  int nchk = 0, nfail = 0, cyc = 0, nmsg = 0, ndone = 0, phase = 0;
  logic [FW-1:0] qm [N][MAXF];
  bit  qh [N][MAXF];
  int  qid [N][MAXF];
  int  qwr [N], qrd [N];
  bit  pop [N];
  int  m_src [MAXM], m_dst [MAXM], m_len [MAXM], m_hops [MAXM], m_inj [MAXM];
  int  lrem [N][DIM], lid [N][DIM];
  int  drem [N], did [N], dseq [N];
  bit  dhdr [N];
  bit  prev_stall [N];
  logic [FW-1:0] prev_d [N];
  int  ord [8];
  int  nord = 0;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int low_bit(input int x);
    int t;
    t = x & (~x + 1);
    return $clog2(t);
  endfunction

  task automatic add_msg(input int s, input int d, input int len);
    int id;
    id = nmsg++;
    m_src[id] = s; m_dst[id] = d; m_len[id] = len; m_hops[id] = 0;
    qm[s][qwr[s]] = FW'((id << (FW-8)) | (len << DIM) | d);
    qh[s][qwr[s]] = 1'b1; qid[s][qwr[s]] = id; qwr[s]++;
    for (int p = 0; p < len; p++) begin
      qm[s][qwr[s]] = FW'((id << (FW-8)) | p);
      qh[s][qwr[s]] = 1'b0; qid[s][qwr[s]] = id; qwr[s]++;
    end
  endtask

  task automatic observe();
    for (int n = 0; n < N; n++) begin
      logic [FW-1:0] f;
      int id;
      pop[n] = inj_v[n] && ir[n][DIM];
      if (pop[n] && qh[n][qrd[n]]) m_inj[qid[n][qrd[n]]] = cyc;
      for (int k = 0; k < DIM; k++) begin
        if (ov[n][k] && orr[n][k]) begin
          f = odt[n][k*FW +: FW];
          id = int'(f >> (FW-8));
          if (lrem[n][k] == 0) begin
            chk(k == low_bit(n ^ m_dst[id]), "R3 dimension order", k, low_bit(n ^ m_dst[id]));
            m_hops[id]++;
            lrem[n][k] = m_len[id];
            lid[n][k] = id;
          end else begin
            chk(id == lid[n][k], "R6 link interleave", id, lid[n][k]);
            lrem[n][k]--;
          end
        end
      end
      if (prev_stall[n])
        chk(ov[n][DIM] && odt[n][DIM*FW +: FW] == prev_d[n], "R8 stalled output held",
            int'(odt[n][DIM*FW +: FW]), int'(prev_d[n]));
      prev_stall[n] = ov[n][DIM] && !dly_r[n];
      prev_d[n] = odt[n][DIM*FW +: FW];
      if (ov[n][DIM] && dly_r[n]) begin
        f = odt[n][DIM*FW +: FW];
        id = int'(f >> (FW-8));
        if (dhdr[n]) begin
          chk(m_dst[id] == n, "R2 delivered at destination", n, m_dst[id]);
          chk(m_hops[id] == $countones(m_src[id] ^ m_dst[id]), "R4 hop count",
              m_hops[id], $countones(m_src[id] ^ m_dst[id]));
          if (n == 0 && phase <= 2 && nord < 8) ord[nord++] = m_src[id];
          if (id == 0) chk(cyc - m_inj[id] == 2, "R9 one cycle per hop", cyc - m_inj[id], 2);
          did[n] = id; dseq[n] = 0; drem[n] = m_len[id];
          if (m_len[id] == 0) ndone++; else dhdr[n] = 1'b0;
        end else begin
          chk(id == did[n], "R6 delivery interleave", id, did[n]);
          chk(int'(f[7:0]) == dseq[n], "R5 payload order", int'(f[7:0]), dseq[n]);
          dseq[n]++; drem[n]--;
          if (drem[n] == 0) begin ndone++; dhdr[n] = 1'b1; end
        end
      end
    end
  endtask

  task automatic advance_phase();
    if (phase == 0) begin
      add_msg(1, 0, 2); add_msg(2, 0, 2); phase = 1;
    end else if (phase == 1 && ndone == nmsg) begin
      chk(nord == 2 && ord[0] == 1 && ord[1] == 2, "R7 first grant from input 0", ord[0], 1);
      if (DIM >= 3) begin
        add_msg(4, 0, 1); add_msg(1, 0, 1); add_msg(2, 0, 1); phase = 2;
      end else phase = 3;
    end else if (phase == 2 && ndone == nmsg) begin
      chk(nord == 5 && ord[2] == 4 && ord[3] == 1 && ord[4] == 2, "R7 rotated grant order",
          ord[2], 4);
      phase = 3;
    end
    if (phase == 3 && ndone == nmsg) begin
      for (int n = 0; n < N; n++)
        for (int j = 0; j < 6; j++) begin
          lcg = lcg * 32'd1103515245 + 32'd12345;
          add_msg(n, int'(lcg[23:16]) % N, int'(lcg[9:8]));
        end
      phase = 4;
    end
  endtask

  task automatic drive();
    advance_phase();
    for (int n = 0; n < N; n++) begin
      if (pop[n]) qrd[n]++;
      inj_v[n] = qrd[n] < qwr[n];
      inj_d[n] = qm[n][qrd[n]];
      dly_r[n] = (phase < 4) ? 1'b1 : (((cyc + n) % 4) != 0);
    end
  endtask

  initial begin
    bit finished;
    finished = 1'b0;
    for (int n = 0; n < N; n++) begin
      inj_v[n] = 1'b0; inj_d[n] = '0; dly_r[n] = 1'b1; qwr[n] = 0; qrd[n] = 0;
      pop[n] = 1'b0; drem[n] = 0; did[n] = 0; dseq[n] = 0; dhdr[n] = 1'b1;
      prev_stall[n] = 1'b0; prev_d[n] = '0;
      for (int k = 0; k < DIM; k++) begin lrem[n][k] = 0; lid[n][k] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ov[0] == '0, "R1 outputs idle after reset", int'(ov[0]), 0);
    chk(ir[0][DIM] == 1'b0, "R1 no grant without request", int'(ir[0][DIM]), 0);
    @(posedge clk); #1 drive();
    for (int c = 0; c < 20000 && !finished; c++) begin
      @(negedge clk);
      observe();
      @(posedge clk);
      cyc++;
      #1 drive();
      if (phase == 4 && ndone == nmsg) finished = 1'b1;
    end
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d delivered expected %0d", ndone, nmsg);
    end
    chk(ndone == nmsg, "R4 all messages delivered", ndone, nmsg);
    for (int n = 0; n < N; n++)
      chk(ov[n] == '0, "R8 network drained", int'(ov[n]), 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule